// File: doc/BRIEF.md
# Macroblock Decoder Flow Controller

This block surrounds a macroblock decoder with its buffering and pacing logic. Command and parameter traffic arrives as 32-bit words. Each parameter word is split into two halfwords and held in a 16-bit input queue. Decoded pixels leave through a 32-bit output queue, which the host or a DMA engine drains one word at a time.

The block raises an inbound DMA request while there is room for more parameter data. It raises an outbound DMA request while pixels wait to be collected. It holds off each decode unit until the output queue can take that unit's whole result. The reserved amount depends on the selected output format.

The decode arithmetic is modelled by a stub. Each unit takes one parameter word, which is two halfwords. It emits one word per cycle, and the number of words it emits is the exact output size of that format. Output word k of a unit equals the parameter word plus k, modulo 2^32. A status word reports the queue flags, the request lines, the format, a rotated block index and the parameter words still due.

Top module: `mbdec_flow`

## Requirements
- R1: While no command is active, a write whose bits [31:29] are 3'b001 starts a decode command, and bits [15:0] give the parameter word count. A write with any other opcode in that state is ignored.
- R2: While a command is active and words remain due, a write is stored as two halfwords, low half first, and the due count drops by one. Output word k of the unit built from that write equals the written word plus k. With no write, the due count does not change.
- R3: `din_req` is high only when inbound DMA is enabled, the input queue has at least 64 free halfword slots, and the output queue is not full.
- R4: `dout_req` is high exactly when outbound DMA is enabled and the output queue holds at least one word.
- R5: Monochrome formats are depth code 0, which reserves 8 words, and depth code 1, which reserves 16 words. A unit starts only when that many output words are free.
- R6: Colour formats are depth code 2, which reserves 192 words, and depth code 3, which reserves 128 words. A unit starts only when that many output words are free.
- R7: A command completes once no words are due, the input queue is empty and the last unit has been emitted. Completion clears the block index and returns the block to the idle state.
- R8: The status word layout is as follows. Bit 31 is output-empty. Bit 30 is input-full. Bit 29 is busy and always reads 0. Bit 28 is `din_req` and bit 27 is `dout_req`. Bits [26:25] hold the depth code. Bits [18:16] hold (block index + 4) mod 6, where the block index counts started units mod 6. Bits [15:0] hold the due count minus 1, truncated to 16 bits. Out of reset the block index is 0 and the due count is 0.
- R9: A read while the output queue is empty returns 32'hFFFFFFFF and removes nothing. Any other read returns the oldest word and removes it.
- R10: A soft reset clears both DMA enables, empties both queues and ends any active command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Load the enable and depth settings |
| ctl_in_en | input | 1 | Inbound DMA enable |
| ctl_out_en | input | 1 | Outbound DMA enable |
| ctl_depth | input | 2 | Output format code |
| soft_rst | input | 1 | Soft reset pulse |
| cmd_wr | input | 1 | Command or parameter write strobe |
| cmd_data | input | 32 | Command or parameter word |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 32 | Oldest output word, or all ones when the queue is empty |
| status | output | 32 | Status word |
| din_req | output | 1 | Inbound DMA request |
| dout_req | output | 1 | Outbound DMA request |

## Verification
Two functions can act on the same cycle.

The first pair is on the output queue. A read can remove a word in the same cycle that the emitter pushes one. The bench provokes this by reading continuously while units are emitting, and the scoreboard judges the result by order and value.

The second pair is on the input queue. A parameter write can push two halfwords in the cycle that a unit start pops two. Back-to-back writes provoke this. The check is that no unit is lost, each output word equals its written word plus its index, and the command then completes.

// File: rtl/mbdec_flow.sv
module mbdec_flow #(
  parameter int IN_DEPTH  = 128,
  parameter int OUT_DEPTH = 256,
  parameter int REQ_SLOTS = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_wr,
  input  logic        ctl_in_en,
  input  logic        ctl_out_en,
  input  logic [1:0]  ctl_depth,
  input  logic        soft_rst,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic [31:0] status,
  output logic        din_req,
  output logic        dout_req
);
  localparam int IAW = $clog2(IN_DEPTH);
  localparam int OAW = $clog2(OUT_DEPTH);
  localparam logic [IAW:0] IN_MAX  = (IAW+1)'(IN_DEPTH);
  localparam logic [OAW:0] OUT_MAX = (OAW+1)'(OUT_DEPTH);

  logic [15:0]    in_mem [IN_DEPTH];
  logic [31:0]    out_mem [OUT_DEPTH];
  logic [IAW-1:0] in_wp, in_rp;
  logic [IAW:0]   in_cnt;
  logic [OAW-1:0] out_wp, out_rp;
  logic [OAW:0]   out_cnt;
  logic           in_en, out_en, busy;
  logic [1:0]     depth;
  logic [15:0]    due;
  logic [2:0]     blk;
  logic [7:0]     emit_left;
  logic [31:0]    emit_word;
  logic [7:0]     need;

  always_comb begin
    case (depth)
      2'd0:    need = 8'd8;
      2'd1:    need = 8'd16;
      2'd2:    need = 8'd192;
      default: need = 8'd128;
    endcase
  end

  wire in_push  = cmd_wr && busy && due != 16'd0 && in_cnt <= IN_MAX - 2;
  wire out_free_ok = (OUT_MAX - out_cnt) >= (OAW+1)'(need);
  wire start    = busy && emit_left == 8'd0 && in_cnt >= 2 && out_free_ok;
  wire out_push = emit_left != 8'd0;
  wire out_pop  = rd_en && out_cnt != '0;
  wire done     = busy && due == 16'd0 && in_cnt == '0 && emit_left == 8'd0;
  wire accept   = cmd_wr && !busy && cmd_data[31:29] == 3'b001;

  wire out_empty = out_cnt == '0;
  wire in_full   = in_cnt == IN_MAX;
  wire [2:0] rot_blk = (blk >= 3'd2) ? blk - 3'd2 : blk + 3'd4;

  assign din_req  = in_en && (IN_MAX - in_cnt) >= (IAW+1)'(REQ_SLOTS) && out_cnt != OUT_MAX;
  assign dout_req = out_en && !out_empty;
  assign rd_data  = out_empty ? 32'hFFFF_FFFF : out_mem[out_rp];
  assign status   = {out_empty, in_full, 1'b0, din_req, dout_req, depth,
                     6'd0, rot_blk, due - 16'd1};

  always_ff @(posedge clk) begin
    if (in_push) begin
      in_mem[in_wp]             <= cmd_data[15:0];
      in_mem[in_wp + IAW'(1)]   <= cmd_data[31:16];
    end
    if (out_push) out_mem[out_wp] <= emit_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_en <= 1'b0; out_en <= 1'b0; depth <= 2'd0;
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
      busy <= 1'b0; due <= 16'd0; blk <= 3'd0;
      emit_left <= 8'd0; emit_word <= 32'd0;
    end else if (soft_rst) begin
      in_en <= 1'b0; out_en <= 1'b0;
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
      busy <= 1'b0; due <= 16'd0; blk <= 3'd0;
      emit_left <= 8'd0;
    end else begin
      if (ctl_wr) begin
        in_en  <= ctl_in_en;
        out_en <= ctl_out_en;
        depth  <= ctl_depth;
      end
      if (accept) begin
        busy <= 1'b1;
        due  <= cmd_data[15:0];
      end else if (in_push) begin
        due <= due - 16'd1;
      end
      if (in_push) in_wp <= in_wp + IAW'(2);
      if (start) begin
        in_rp     <= in_rp + IAW'(2);
        emit_left <= need;
        emit_word <= {in_mem[in_rp + IAW'(1)], in_mem[in_rp]};
        blk       <= (blk == 3'd5) ? 3'd0 : blk + 3'd1;
      end else if (out_push) begin
        emit_left <= emit_left - 8'd1;
        emit_word <= emit_word + 32'd1;
      end
      in_cnt <= in_cnt + (in_push ? (IAW+1)'(2) : '0) - (start ? (IAW+1)'(2) : '0);
      if (out_push) out_wp <= out_wp + OAW'(1);
      if (out_pop)  out_rp <= out_rp + OAW'(1);
      out_cnt <= out_cnt + (OAW+1)'(out_push) - (OAW+1)'(out_pop);
      if (done) begin
        busy <= 1'b0;
        blk  <= 3'd0;
      end
    end
  end
endmodule

// File: rtl/mbdec_flow_chk.sv
module mbdec_flow_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        soft_rst,
  input logic        cmd_wr,
  input logic        rd_en,
  input logic [31:0] rd_data,
  input logic [31:0] status,
  input logic        din_req,
  input logic        dout_req
);
  // R9
  empty_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && status[31]) |-> rd_data == 32'hFFFF_FFFF);

  // R4
  dout_req_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_req |-> !status[31]);

  // R3
  din_req_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    din_req |-> !status[30]);

  // R10
  soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!din_req && !dout_req && status[31] && status[15:0] == 16'hFFFF));

  // R2
  due_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_wr && !soft_rst) |=> $stable(status[15:0]));
endmodule

bind mbdec_flow mbdec_flow_chk u_chk (.*);

// File: tb/mbdec_flow_tb.sv
module mbdec_flow_tb;
  logic clk = 0, rst_n = 0;
  logic ctl_wr = 0, ctl_in_en = 0, ctl_out_en = 0, soft_rst = 0;
  logic [1:0] ctl_depth = 0;
  logic cmd_wr = 0, rd_en = 0;
  logic [31:0] cmd_data = 0;
  logic [31:0] rd_data, status;
  logic din_req, dout_req;

  int checks = 0, errors = 0, cur_len = 8;
  bit mon_on = 0;
  logic [31:0] q[$];

  always #5 clk = ~clk;

  mbdec_flow u_dut (.*);

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int len_of(int d);
    return d == 0 ? 8 : d == 1 ? 16 : d == 2 ? 192 : 128;
  endfunction

  task automatic ctl(bit ie, bit oe, int d);
    ctl_wr = 1; ctl_in_en = ie; ctl_out_en = oe; ctl_depth = 2'(d); cur_len = len_of(d);
    @(negedge clk); ctl_wr = 0;
  endtask

  task automatic cmd(logic [31:0] w);
    cmd_wr = 1; cmd_data = w; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic send(logic [31:0] w);
    for (int k = 0; k < cur_len; k++) q.push_back(w + 32'(k));
    cmd_wr = 1; cmd_data = w; @(negedge clk); cmd_wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops and compares scoreboard items as the design emits words
  always @(negedge clk) begin
    if (mon_on && !status[31]) begin
      if (q.size() == 0) check(0, "R2 unexpected word", rd_data, 0);
      else begin
        logic [31:0] e;
        e = q.pop_front();
        check(rd_data == e, "R2 word order/value", rd_data, e);
      end
      rd_en = 1;
    end else if (mon_on) rd_en = 0;
  end

  task automatic read_n(int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] e;
      e = q.size() ? q.pop_front() : 32'hDEAD_BEEF;
      check(!status[31] && rd_data == e, "R9 read", rd_data, e);
      rd_en = 1; @(negedge clk); rd_en = 0;
    end
  endtask

  task automatic drain(int n);
    mon_on = 1; idle(n); mon_on = 0; rd_en = 0;
    check(q.size() == 0, "R2 scoreboard drained", q.size(), 0);
    check(status[31] == 1, "R9 output empty", status[31], 1);
  endtask

  task automatic stall_test(int d, string req);
    int fill, free, kf;
    ctl(1, 0, d);
    fill = 256 / cur_len;
    free = 256 - fill * cur_len;
    cmd({3'b001, 13'd0, 16'(fill + 1)});
    for (int i = 0; i <= fill; i++) send(32'h1000_0000 * (d + 1) + 32'(i * 1024));
    idle(fill * cur_len + 40);
    kf = ((fill % 6) + 4) % 6;
    check(status[18:16] == 3'(kf), {req, " stalled unit"}, status[18:16], kf);
    read_n(cur_len - free - 1);
    idle(20);
    check(status[18:16] == 3'(kf), {req, " still below threshold"}, status[18:16], kf);
    read_n(1);
    idle(cur_len + 20);
    check(status[18:16] == 3'd4, {req, " R7 block reset after start"}, status[18:16], 4);
    check(status[15:0] == 16'hFFFF, {req, " R7 idle due"}, status[15:0], 16'hFFFF);
    drain(300);
  endtask

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    check(status[31] && !din_req && !dout_req, "R8 reset flags", status, 0);
    check(status[18:16] == 3'd4, "R8 reset block field", status[18:16], 4);
    check(status[15:0] == 16'hFFFF, "R8 reset due field", status[15:0], 16'hFFFF);
    check(status[29] == 0, "R8 busy bit", status[29], 0);
    rd_en = 1;
    check(rd_data == 32'hFFFF_FFFF, "R9 empty read", rd_data, 32'hFFFF_FFFF);
    @(negedge clk); rd_en = 0;
    check(status[31] == 1, "R9 empty read pops nothing", status[31], 1);

    ctl(1, 1, 1);
    check(din_req == 1 && status[28] == 1, "R3 idle request", din_req, 1);
    check(dout_req == 0, "R4 no data", dout_req, 0);
    check(status[26:25] == 2'd1, "R8 depth field", status[26:25], 1);

    cmd(32'h4000_0005);
    check(status[15:0] == 16'hFFFF, "R1 other opcode ignored", status[15:0], 16'hFFFF);
    cmd(32'h2000_0003);
    check(status[15:0] == 16'd2, "R1 count accepted", status[15:0], 2);
    send(32'h1234_5678);
    check(status[15:0] == 16'd1, "R2 due decrement", status[15:0], 1);
    idle(20);
    check(dout_req == 1 && status[27] == 1, "R4 data waiting", dout_req, 1);
    check(rd_data == 32'h1234_5678, "R2 low half first", rd_data, 32'h1234_5678);
    mon_on = 1;
    send(32'hFFFF_FFF8);
    send(32'hA5A5_0000);
    idle(80);
    mon_on = 0; rd_en = 0;
    check(q.size() == 0, "R2 all words seen", q.size(), 0);
    check(status[15:0] == 16'hFFFF && status[18:16] == 3'd4, "R7 completion", status, 0);
    check(dout_req == 0, "R4 drained", dout_req, 0);

    stall_test(0, "R5 4-bit");
    stall_test(1, "R5 8-bit");
    stall_test(2, "R6 24-bit");
    stall_test(3, "R6 15-bit");

    ctl(1, 1, 3);
    cmd(32'h2000_0002);
    send(32'h0); send(32'h100);
    idle(300);
    check(din_req == 0 && status[28] == 0, "R3 output full", din_req, 0);
    read_n(1);
    check(din_req == 1, "R3 output not full", din_req, 1);
    drain(300);

    ctl(1, 0, 2);
    cmd(32'h2000_0041);
    for (int i = 0; i < 33; i++) send(32'(i) << 12);
    idle(2);
    check(din_req == 1, "R3 exactly 64 free", din_req, 1);
    send(32'(33) << 12);
    idle(2);
    check(din_req == 0, "R3 62 free", din_req, 0);
    for (int i = 34; i < 65; i++) send(32'(i) << 12);
    idle(2);
    check(status[30] == 1, "R8 input full flag", status[30], 1);
    drain(13000);
    check(status[15:0] == 16'hFFFF, "R7 long command done", status[15:0], 16'hFFFF);

    ctl(1, 1, 1);
    cmd(32'h2000_0004);
    send(32'h55); send(32'h66);
    idle(6);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    q.delete();
    check(!din_req && !dout_req, "R10 enables cleared", {din_req, dout_req}, 0);
    check(status[31] == 1 && rd_data == 32'hFFFF_FFFF, "R10 output emptied", rd_data, 32'hFFFF_FFFF);
    check(status[15:0] == 16'hFFFF && status[18:16] == 3'd4, "R10 command ended", status, 0);
    idle(30);
    check(status[31] == 1, "R10 nothing emitted later", status[31], 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    check(0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule